// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block conditions a small set of asynchronous external interrupt request pins and turns each into a clean request toward the interrupt arbiter. A control register holds one 2-bit sense field per pin, which picks falling-edge detection, rising-edge detection or low-level detection for that pin. A fourth code is reserved and silences the pin. Edge-mode requests are sticky and are cleared by a per-source acknowledge pulse. Level-mode requests simply track the pin.

The same register carries an enable for a separate 4-bit encoded interrupt-level input group. That enable only matters while an external level-mode control input is high. When both are set, the encoded pins are synchronised and presented as a 4-bit code. Otherwise the code is forced to all ones, which means no request.

Every raw pin passes through a two-flop synchroniser before it is used. All pins are active low and idle high. Priority arbitration and vectoring are handled elsewhere.

Top module: `eint_sense_ctrl`

## Requirements
- R1: After reset the register reads 0 (every sense field 00, encoded enable 0), every request output is 0 and the encoded code output is 4'hF.
- R2: The sense field of source i sits at register bits 6+2i+1:6+2i (source 0 at 7:6, source 1 at 9:8, source 2 at 11:10) and the encoded enable sits at bit 12. A write stores these bits and they read back unchanged. All other bits read 0.
- R3: With field 00, a high-to-low transition of the pin raises the source's request on the third rising clock edge after the pin changes, and the request stays up. A rising transition sets nothing.
- R4: With field 01, a low-to-high transition of the pin raises the request with the same three-edge latency. A falling transition sets nothing.
- R5: In either edge mode a raised request stays up until the source's acknowledge bit is high at a clock edge. If a new edge is detected in the same cycle as the acknowledge, the request stays set.
- R6: With field 10, the request is the inverse of the pin delayed by the two synchroniser edges, with no latching. It drops as soon as the synchronised pin is high.
- R7: With field 11, the source's request output is 0 whatever the pin does. A request that was pending in an edge mode is discarded, so it does not return when the field is written back to an edge mode.
- R8: An edge that reaches detection in the same cycle that a write changes that source's field is discarded.
- R9: While the encoded enable (bit 12) is 1 and the level-mode input is 1, the code output equals the encoded pins delayed by two clock edges.
- R10: While either the encoded enable or the level-mode input is 0, the code output is 4'hF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | REG_W (16) | Register write data |
| reg_rdata_o | output | REG_W (16) | Register read data |
| irq_pin_i | input | NUM_SRC (3) | Raw asynchronous interrupt pins, active low |
| irq_ack_i | input | NUM_SRC (3) | Per-source acknowledge for latched requests |
| irq_req_o | output | NUM_SRC (3) | Per-source request outputs |
| lvl_mode_i | input | 1 | Level-mode control that qualifies the encoded enable |
| enc_pin_i | input | ENC_W (4) | Raw encoded interrupt-level pins |
| enc_code_o | output | ENC_W (4) | Qualified, synchronised encoded level, all ones when idle |

## Verification
The bench aims at the boundaries between modes. One case is a pin edge that lands exactly on the write that changes its field: a design that ignores this leaves a phantom request behind. Another is a request that is pending when the field is set to the reserved code. A design that only masks the output would show that stale request again once the field returns to an edge mode. The bench also checks that an acknowledge coinciding with a fresh edge keeps the request set, since a design that gives the acknowledge priority would lose an interrupt. It checks the exact latency through the synchronisers, which an extra or missing stage would shift by a cycle. Finally, it checks the encoded output's dependence on both qualifying bits, where a design that tested only the register bit would leak a code while level mode is off.

// File: rtl/eint_pkg.sv
package eint_pkg;

    typedef enum logic [1:0] {
        SNS_FALL = 2'b00,
        SNS_RISE = 2'b01,
        SNS_LOW  = 2'b10,
        SNS_RSVD = 2'b11
    } sense_e;

    typedef struct packed {
        logic prev;
        logic flag;
    } chan_state_t;

    function automatic logic is_edge_mode(sense_e m);
        return (m == SNS_FALL) || (m == SNS_RISE);
    endfunction

    function automatic logic edge_seen(sense_e m, logic prev, logic cur);
        return ((m == SNS_FALL) && prev && !cur) ||
               ((m == SNS_RISE) && !prev && cur);
    endfunction

endpackage

// File: rtl/eint_sync.sv
module eint_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < STAGES; k++) stg[k] <= '1;
        end else begin
            stg[0] <= d_i;
            for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
        end
    end

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/eint_ctrl_reg.sv
module eint_ctrl_reg #(
    parameter int NUM_SRC   = 3,
    parameter int FIELD_LSB = 6,
    parameter int REG_W     = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_i,
    input  logic [REG_W-1:0]        wdata_i,
    output logic [NUM_SRC-1:0][1:0] fld_o,
    output logic [NUM_SRC-1:0]      chg_o,
    output logic                    enc_en_o,
    output logic [REG_W-1:0]        rdata_o
);
    localparam int EN_BIT = FIELD_LSB + 2 * NUM_SRC;

    logic [NUM_SRC-1:0][1:0] fld_q;
    logic                    en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            fld_q <= '0;
            en_q  <= 1'b0;
        end else if (wr_i) begin
            for (int i = 0; i < NUM_SRC; i++)
                fld_q[i] <= wdata_i[FIELD_LSB + 2*i +: 2];
            en_q <= wdata_i[EN_BIT];
        end
    end

    always_comb begin
        rdata_o = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            rdata_o[FIELD_LSB + 2*i +: 2] = fld_q[i];
            chg_o[i] = wr_i && (wdata_i[FIELD_LSB + 2*i +: 2] != fld_q[i]);
        end
        rdata_o[EN_BIT] = en_q;
    end

    assign fld_o    = fld_q;
    assign enc_en_o = en_q;
endmodule

// File: rtl/eint_sense_chan.sv
module eint_sense_chan
    import eint_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   pin_s_i,
    input  sense_e mode_i,
    input  logic   mode_chg_i,
    input  logic   ack_i,
    output logic   req_o
);
    chan_state_t st_q;
    logic        hit;

    assign hit = edge_seen(mode_i, st_q.prev, pin_s_i) && !mode_chg_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.prev <= 1'b1;
            st_q.flag <= 1'b0;
        end else begin
            st_q.prev <= pin_s_i;
            if (!is_edge_mode(mode_i))
                st_q.flag <= 1'b0;
            else if (hit)
                st_q.flag <= 1'b1;
            else if (ack_i)
                st_q.flag <= 1'b0;
        end
    end

    always_comb begin
        unique case (mode_i)
            SNS_LOW:  req_o = !pin_s_i;
            SNS_RSVD: req_o = 1'b0;
            default:  req_o = st_q.flag;
        endcase
    end
endmodule

// File: rtl/eint_enc_qual.sv
module eint_enc_qual #(
    parameter int ENC_W  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ENC_W-1:0] pin_i,
    input  logic             en_i,
    input  logic             lvl_i,
    output logic [ENC_W-1:0] code_o
);
    logic [ENC_W-1:0] pin_s;

    eint_sync #(.W(ENC_W), .STAGES(STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (pin_i),
        .q_o (pin_s)
    );

    assign code_o = (en_i && lvl_i) ? pin_s : '1;
endmodule

// File: rtl/eint_sense_ctrl.sv
module eint_sense_ctrl
    import eint_pkg::*;
#(
    parameter int NUM_SRC     = 3,
    parameter int FIELD_LSB   = 6,
    parameter int REG_W       = 16,
    parameter int ENC_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr_i,
    input  logic [REG_W-1:0]   reg_wdata_i,
    output logic [REG_W-1:0]   reg_rdata_o,
    input  logic [NUM_SRC-1:0] irq_pin_i,
    input  logic [NUM_SRC-1:0] irq_ack_i,
    output logic [NUM_SRC-1:0] irq_req_o,
    input  logic               lvl_mode_i,
    input  logic [ENC_W-1:0]   enc_pin_i,
    output logic [ENC_W-1:0]   enc_code_o
);
    logic [NUM_SRC-1:0][1:0] fld;
    logic [NUM_SRC-1:0]      chg;
    logic                    enc_en;
    logic [NUM_SRC-1:0]      pin_s;

    eint_ctrl_reg #(.NUM_SRC(NUM_SRC), .FIELD_LSB(FIELD_LSB), .REG_W(REG_W)) u_reg (
        .clk      (clk),
        .rst      (rst),
        .wr_i     (reg_wr_i),
        .wdata_i  (reg_wdata_i),
        .fld_o    (fld),
        .chg_o    (chg),
        .enc_en_o (enc_en),
        .rdata_o  (reg_rdata_o)
    );

    eint_sync #(.W(NUM_SRC), .STAGES(SYNC_STAGES)) u_pin_sync (
        .clk (clk),
        .rst (rst),
        .d_i (irq_pin_i),
        .q_o (pin_s)
    );

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_chan
        eint_sense_chan u_chan (
            .clk        (clk),
            .rst        (rst),
            .pin_s_i    (pin_s[g]),
            .mode_i     (sense_e'(fld[g])),
            .mode_chg_i (chg[g]),
            .ack_i      (irq_ack_i[g]),
            .req_o      (irq_req_o[g])
        );
    end

    eint_enc_qual #(.ENC_W(ENC_W), .STAGES(SYNC_STAGES)) u_enc (
        .clk    (clk),
        .rst    (rst),
        .pin_i  (enc_pin_i),
        .en_i   (enc_en),
        .lvl_i  (lvl_mode_i),
        .code_o (enc_code_o)
    );
endmodule

// File: rtl/eint_sense_chk.sv
module eint_sense_chk #(
    parameter int NUM_SRC   = 3,
    parameter int FIELD_LSB = 6,
    parameter int REG_W     = 16,
    parameter int ENC_W     = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               reg_wr_i,
    input logic [REG_W-1:0]   reg_wdata_i,
    input logic [REG_W-1:0]   reg_rdata_o,
    input logic [NUM_SRC-1:0] irq_ack_i,
    input logic [NUM_SRC-1:0] irq_req_o,
    input logic [ENC_W-1:0]   enc_code_o
);
    localparam int EN_BIT = FIELD_LSB + 2 * NUM_SRC;
    localparam logic [REG_W-1:0] WMASK =
        REG_W'(((64'd1 << (2 * NUM_SRC + 1)) - 64'd1) << FIELD_LSB);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        $past(rst) && !rst |-> reg_rdata_o == '0 && irq_req_o == '0 && enc_code_o == '1);

    // R2
    reg_readback_chk: assert property (@(posedge clk) disable iff (rst)
        reg_wr_i |=> reg_rdata_o == ($past(reg_wdata_i) & WMASK));

    // R10
    enc_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !reg_rdata_o[EN_BIT] |-> enc_code_o == '1);

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        // R5
        sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (reg_rdata_o[FIELD_LSB + 2*g + 1] == 1'b0) && irq_req_o[g] &&
            !irq_ack_i[g] && !reg_wr_i |=> irq_req_o[g]);
        // R7
        reserved_quiet_chk: assert property (@(posedge clk) disable iff (rst)
            reg_rdata_o[FIELD_LSB + 2*g +: 2] == 2'b11 |-> !irq_req_o[g]);
    end
endmodule

bind eint_sense_ctrl eint_sense_chk #(
    .NUM_SRC(NUM_SRC), .FIELD_LSB(FIELD_LSB), .REG_W(REG_W), .ENC_W(ENC_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_wr_i    (reg_wr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .irq_ack_i   (irq_ack_i),
    .irq_req_o   (irq_req_o),
    .enc_code_o  (enc_code_o)
);

// File: tb/eint_sense_ctrl_bench.sv
module eint_sense_ctrl_bench;
    localparam int NS = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [NS-1:0] pin = '1;
    logic [NS-1:0] ack = '0;
    logic [NS-1:0] req;
    logic        lvl = 1'b0;
    logic [3:0]  encp = 4'hF;
    logic [3:0]  enc;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #10ns clk = ~clk;

    eint_sense_ctrl u_eint_sense_ctrl (
        .clk (clk), .rst (rst),
        .reg_wr_i (wr), .reg_wdata_i (wdata), .reg_rdata_o (rdata),
        .irq_pin_i (pin), .irq_ack_i (ack), .irq_req_o (req),
        .lvl_mode_i (lvl), .enc_pin_i (encp), .enc_code_o (enc)
    );

    // behavioural reference model
    int m_fld[NS];
    int m_en;
    int m_s1[NS], m_s2[NS], m_pv[NS], m_fl[NS];
    int m_e1, m_e2;

    always @(posedge clk) begin
        if (rst) begin
            m_en = 0; m_e1 = 15; m_e2 = 15;
            for (int i = 0; i < NS; i++) begin
                m_fld[i] = 0; m_s1[i] = 1; m_s2[i] = 1; m_pv[i] = 1; m_fl[i] = 0;
            end
        end else begin
            for (int i = 0; i < NS; i++) begin
                int md, nf;
                bit hit, chg;
                md  = m_fld[i];
                nf  = (int'(wdata) >> (6 + 2*i)) & 3;
                hit = (md == 0 && m_pv[i] == 1 && m_s2[i] == 0) ||
                      (md == 1 && m_pv[i] == 0 && m_s2[i] == 1);
                chg = wr && (nf != md);
                if (md >= 2) m_fl[i] = 0;
                else if (hit && !chg) m_fl[i] = 1;
                else if (ack[i]) m_fl[i] = 0;
                m_pv[i] = m_s2[i];
                m_s2[i] = m_s1[i];
                m_s1[i] = int'(pin[i]);
                if (wr) m_fld[i] = nf;
            end
            m_e2 = m_e1;
            m_e1 = int'(encp);
            if (wr) m_en = int'(wdata[12]);
        end
    end

    function automatic int exp_req(int i);
        if (m_fld[i] == 2) return (m_s2[i] == 0) ? 1 : 0;
        if (m_fld[i] == 3) return 0;
        return m_fl[i];
    endfunction

    function automatic int exp_enc();
        return (m_en == 1 && lvl) ? m_e2 : 15;
    endfunction

    function automatic int exp_rdata();
        int v = m_en << 12;
        for (int i = 0; i < NS; i++) v |= m_fld[i] << (6 + 2*i);
        return v;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic tick(input int n);
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            for (int i = 0; i < NS; i++) begin
                string tg;
                case (m_fld[i])
                    0: tg = "R3 falling-mode req";
                    1: tg = "R4 rising-mode req";
                    2: tg = "R6 level-mode req";
                    default: tg = "R7 reserved-mode req";
                endcase
                chk(int'(req[i]) == exp_req(i), tg, int'(req[i]), exp_req(i));
            end
            chk(int'(enc) == exp_enc(), (m_en == 1 && lvl) ? "R9 enc code" : "R10 enc idle",
                int'(enc), exp_enc());
            chk(int'(rdata) == exp_rdata(), "R2 readback", int'(rdata), exp_rdata());
        end
    endtask

    task automatic wr_ctrl(input logic [15:0] v);
        wr = 1'b1; wdata = v;
        tick(1);
        wr = 1'b0;
    endtask

    task automatic ack_pulse(input int i);
        ack[i] = 1'b1;
        tick(1);
        ack[i] = 1'b0;
    endtask

    initial begin
        #2_000_000ns;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        tick(3);
        // R1 reset state
        chk(rdata == 16'h0, "R1 rdata", int'(rdata), 0);
        chk(req == '0, "R1 req", int'(req), 0);
        chk(enc == 4'hF, "R1 enc", int'(enc), 15);
        rst = 1'b0;
        tick(2);

        // R2 layout
        wr_ctrl(16'hFFFF);
        chk(rdata == 16'h1FC0, "R2 mask", int'(rdata), 16'h1FC0);
        wr_ctrl(16'h0A40);
        chk(rdata == 16'h0A40, "R2 fields", int'(rdata), 16'h0A40);
        wr_ctrl(16'h0000);
        tick(3);

        // R3 falling edge with latency
        pin[0] = 1'b0;
        tick(2);
        chk(req[0] == 1'b0, "R3 latency early", int'(req[0]), 0);
        tick(1);
        chk(req[0] == 1'b1, "R3 falling edge", int'(req[0]), 1);
        pin[0] = 1'b1;
        tick(4);
        chk(req[0] == 1'b1, "R5 sticky", int'(req[0]), 1);
        ack_pulse(0);
        chk(req[0] == 1'b0, "R5 ack clears", int'(req[0]), 0);

        // R4 rising edge
        wr_ctrl(16'h0100);
        pin[1] = 1'b0;
        tick(4);
        chk(req[1] == 1'b0, "R4 fall ignored", int'(req[1]), 0);
        pin[1] = 1'b1;
        tick(3);
        chk(req[1] == 1'b1, "R4 rising edge", int'(req[1]), 1);
        ack_pulse(1);
        chk(req[1] == 1'b0, "R5 ack clears", int'(req[1]), 0);

        // R5 edge coinciding with ack
        pin[1] = 1'b0;
        tick(3);
        pin[1] = 1'b1;
        tick(2);
        ack_pulse(1);
        chk(req[1] == 1'b1, "R5 edge beats ack", int'(req[1]), 1);
        ack_pulse(1);
        chk(req[1] == 1'b0, "R5 ack clears", int'(req[1]), 0);

        // R6 level mode
        wr_ctrl(16'h0900);
        pin[2] = 1'b0;
        tick(1);
        chk(req[2] == 1'b0, "R6 sync delay", int'(req[2]), 0);
        tick(1);
        chk(req[2] == 1'b1, "R6 low level", int'(req[2]), 1);
        pin[2] = 1'b1;
        tick(2);
        chk(req[2] == 1'b0, "R6 no latch", int'(req[2]), 0);

        // R7 reserved discards pending
        pin[0] = 1'b0;
        tick(3);
        chk(req[0] == 1'b1, "R3 falling edge", int'(req[0]), 1);
        wr_ctrl(16'h09C0);
        chk(req[0] == 1'b0, "R7 reserved quiet", int'(req[0]), 0);
        pin[0] = 1'b1;
        tick(3);
        wr_ctrl(16'h0900);
        tick(1);
        chk(req[0] == 1'b0, "R7 pending discarded", int'(req[0]), 0);

        // R8 edge on the mode-change write
        pin[0] = 1'b0;
        tick(2);
        wr_ctrl(16'h0940);
        chk(req[0] == 1'b0, "R8 change cycle", int'(req[0]), 0);
        tick(2);
        chk(req[0] == 1'b0, "R8 no phantom", int'(req[0]), 0);
        pin[0] = 1'b1;
        tick(3);
        chk(req[0] == 1'b1, "R4 rising edge", int'(req[0]), 1);
        ack_pulse(0);

        // R9 / R10 encoded group
        encp = 4'h5; lvl = 1'b0;
        wr_ctrl(16'h1940);
        tick(3);
        chk(enc == 4'hF, "R10 level-mode off", int'(enc), 15);
        lvl = 1'b1;
        tick(1);
        chk(enc == 4'h5, "R9 qualified", int'(enc), 5);
        encp = 4'hA;
        tick(1);
        chk(enc == 4'h5, "R9 delay", int'(enc), 5);
        tick(1);
        chk(enc == 4'hA, "R9 new code", int'(enc), 10);
        wr_ctrl(16'h0940);
        chk(enc == 4'hF, "R10 enable off", int'(enc), 15);

        // mixed random traffic against the model
        for (int c = 0; c < 600; c++) begin
            pin  = NS'($urandom);
            ack  = NS'($urandom) & NS'($urandom);
            encp = 4'($urandom);
            if (($urandom % 16) == 0) lvl = ~lvl;
            if (($urandom % 12) == 0) begin
                wr = 1'b1; wdata = 16'($urandom);
            end else begin
                wr = 1'b0;
            end
            tick(1 + ($urandom % 3));
        end
        wr = 1'b0; ack = '0;
        tick(4);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule